// File: doc/BRIEF.md
# Register-Mapped SPI Host Controller

This block is a single-word SPI host that a processor drives through a small 32-bit register window. Software first chooses one of eight chip-select lines and whether it is asserted. It then sets clock polarity, clock phase, the bit order of each direction and the word size (8 or 16 bits). A write to the transmit register starts one full-duplex exchange, and software polls a completion register until it reads nonzero. It then reads the received word and clears the completion flag.

The serial clock is paced by a single-cycle enable pulse (`sclk_tick`) from an external prescaler. Each pulse moves SCLK by one edge, so one SCLK period takes two pulses. A programmable sample-point field can move the MISO capture one core clock past the sampling edge. This gives a slow target more time to drive MISO in the fastest modes.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset all chip selects are high, SCLK and MOSI are low, the completion register reads 0, the timing register (byte offset 0x18) reads 0x40 (sample field = 1) and the control, configuration, data-out and data-in registers read 0.
- R2: Control register (offset 0x00): bits [4:2] hold a select number and bit 0 is the assert flag. With bit 0 set, only `cs_n[select]` is low. With bit 0 clear, every `cs_n` is high. The register reads back what was written.
- R3: While no exchange is running, SCLK sits at the polarity bit (configuration offset 0x04, bit 11). It is back at that level when an exchange completes.
- R4: A write to data out (offset 0x08) while idle starts an exchange of N bits, where N is 16 when configuration bit 5 is set and 8 otherwise. SCLK makes exactly 2N edges, one per `sclk_tick`.
- R5: Configuration bit 12 is the phase. When it is 0, each MOSI bit is valid before the leading edge and MISO is sampled on leading edges. When it is 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R6: Configuration bit 13 set sends the word LSB first. When it is clear, bit N-1 is sent first.
- R7: Configuration bit 14 alone sets the receive order. When it is set, the first received bit lands in bit 0. When it is clear, the first received bit lands in bit N-1.
- R8: The completion register (offset 0x10) reads 1 from a few cycles after the last edge until any write to it, which clears it to 0. A completion in the same cycle as that write wins.
- R9: Data in (offset 0x0C) holds the last received word in bits [N-1:0], with all higher bits zero. It changes only when an exchange completes.
- R10: A data-out write during an exchange is ignored. The exchange in flight is unchanged, data out still reads the first word, and there is no extra completion.
- R11: Timing bits [7:6] form the sample field. A value of 2 captures MISO one core clock after the sampling edge. Any other value captures MISO at the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sclk_tick | input | 1 | One-cycle pulse from the prescaler, one per SCLK edge |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Host-to-target data |
| miso | input | 1 | Target-to-host data |
| cs_n | output | 8 | Active-low chip selects |

## Verification
Register writes take effect at the next clock edge, and reads are combinational, so the bench reads each register one cycle after writing it. An exchange needs 2N prescaler pulses plus one or two cycles to finish (two with sample field 2), and then one more cycle before the completion flag shows. The bench polls that flag and requires the measured latency to fall between 2N·P−P and 2N·P+P+6 cycles, where P is the pulse period. A target model acts on the falling core-clock edge after each SCLK edge, so MISO never changes in a cycle where the host samples it. The exception is an "early" target that changes MISO right after the sampling edge, which separates immediate capture from delayed capture.

// File: rtl/spim_pkg.sv
// Shared constants and types of the SPI host controller.
// Assumes byte-offset addressing of 32-bit registers.
package spim_pkg;
    // Register byte offsets (software-visible, fixed)
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_CFG    = 'h04;
    localparam int OFF_DOUT   = 'h08;
    localparam int OFF_DIN    = 'h0C;
    localparam int OFF_CAUSE  = 'h10;
    localparam int OFF_TIMING = 'h18;

    // Field positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SEL_LSB  = 2;
    localparam int CFG_WIDE_BIT  = 5;
    localparam int CFG_CPOL_BIT  = 11;
    localparam int CFG_CPHA_BIT  = 12;
    localparam int CFG_TXLSB_BIT = 13;
    localparam int CFG_RXLSB_BIT = 14;
    localparam int TIM_SMP_LSB   = 6;
    localparam logic [1:0] SMP_DEFAULT = 2'd1;
    localparam logic [1:0] SMP_LATE    = 2'd2;

    // Shape of one exchange, latched by the shift engine at start
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic tx_lsb;
        logic rx_lsb;
        logic wide;
        logic late;
    } spim_shape_t;
endpackage

// File: rtl/spim_cs_decode.sv
// Chip-select decoder: drives one active-low select for the programmed
// number while the assert flag is set, none otherwise.
// Assumes CS_COUNT is a power of two.
module spim_cs_decode #(
    parameter int CS_COUNT = 8,
    localparam int SEL_W = $clog2(CS_COUNT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [SEL_W-1:0]    sel,
    output logic [CS_COUNT-1:0] cs_n
);
    // One comparator per select line
    for (genvar g = 0; g < CS_COUNT; g++) begin : g_line
        assign cs_n[g] = ~(en && (sel == SEL_W'(g)));
    end

    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    a_r2_none_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (&cs_n));
endmodule

// File: rtl/spim_shift_engine.sv
// Shift engine: runs one full-duplex exchange of 8 or MAXW bits.
// Each sclk_tick toggles SCLK. Bit positions are chosen per direction
// from the latched bit order, so no bit reversal logic is needed.
// Assumes sclk_tick pulses are at least one cycle apart when the
// delayed sample point is used with a target changing MISO late.
module spim_shift_engine
    import spim_pkg::*;
#(
    parameter int MAXW   = 16,
    parameter int SHORTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MAXW-1:0] tx_word,
    input  spim_shape_t     shape,
    input  logic            tick,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi,
    output logic            busy,
    output logic            done,
    output logic [MAXW-1:0] rx_word
);
    localparam int CNT_W = $clog2(2 * MAXW + 1);
    localparam int IDX_W = $clog2(MAXW);

    logic              busy_q, done_q, sclk_q, pend_q;
    logic [CNT_W-1:0]  edge_q;
    spim_shape_t       shp_q;
    logic [MAXW-1:0]   txw_q, rxw_q;
    logic [IDX_W-1:0]  pend_pos_q;

    logic [CNT_W-1:0]  nbits, last_edge, out_raw;
    logic [IDX_W-1:0]  nbits_m1, out_idx, tx_pos, smp_idx, rx_pos;
    logic              advance, sample_edge;

    // Bit-position arithmetic for the current edge count
    always_comb begin
        nbits     = shp_q.wide ? CNT_W'(MAXW) : CNT_W'(SHORTW);
        last_edge = nbits << 1;
        nbits_m1  = IDX_W'(nbits - CNT_W'(1));
        if (shp_q.cpha)
            out_raw = (edge_q == '0) ? '0 : ((edge_q - CNT_W'(1)) >> 1);
        else
            out_raw = edge_q >> 1;
        out_idx     = (out_raw >= nbits) ? nbits_m1 : IDX_W'(out_raw);
        tx_pos      = shp_q.tx_lsb ? out_idx : (nbits_m1 - out_idx);
        smp_idx     = IDX_W'(edge_q >> 1);
        rx_pos      = shp_q.rx_lsb ? smp_idx : (nbits_m1 - smp_idx);
        sample_edge = (edge_q[0] == shp_q.cpha);
        advance     = busy_q && tick && (edge_q < last_edge);
    end

    // Exchange sequencing, SCLK toggling and MISO capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            sclk_q     <= 1'b0;
            pend_q     <= 1'b0;
            edge_q     <= '0;
            shp_q      <= '0;
            txw_q      <= '0;
            rxw_q      <= '0;
            pend_pos_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    shp_q  <= shape;
                    txw_q  <= tx_word;
                    rxw_q  <= '0;
                    edge_q <= '0;
                    sclk_q <= shape.cpol;
                    pend_q <= 1'b0;
                end
            end else begin
                if (pend_q) begin
                    rxw_q[pend_pos_q] <= miso;
                    pend_q            <= 1'b0;
                end
                if (advance) begin
                    sclk_q <= ~sclk_q;
                    edge_q <= edge_q + CNT_W'(1);
                    if (sample_edge) begin
                        if (shp_q.late) begin
                            pend_q     <= 1'b1;
                            pend_pos_q <= rx_pos;
                        end else begin
                            rxw_q[rx_pos] <= miso;
                        end
                    end
                end else if (edge_q == last_edge && !pend_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign sclk    = busy_q ? sclk_q : shape.cpol;
    assign mosi    = busy_q & txw_q[tx_pos];
    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_word = rxw_q;

    a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (edge_q <= last_edge));
    a_r3_sclk_home: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (sclk_q == shp_q.cpol));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r10_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> $stable(txw_q));
endmodule

// File: rtl/spim_regs.sv
// Register file: decodes writes, holds the control, configuration,
// timing, data and completion state, and returns read data.
// Assumes single-cycle writes and combinational reads.
module spim_regs
    import spim_pkg::*;
#(
    parameter int MAXW     = 16,
    parameter int CS_COUNT = 8,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    localparam int SEL_W = $clog2(CS_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [MAXW-1:0]   rx_word,
    output logic              start,
    output logic [MAXW-1:0]   tx_word,
    output spim_shape_t       shape,
    output logic              cs_en,
    output logic [SEL_W-1:0]  cs_sel
);
    logic              en_q, cpol_q, cpha_q, txl_q, rxl_q, wide_q, cause_q;
    logic [SEL_W-1:0]  sel_q;
    logic [1:0]        smp_q;
    logic [MAXW-1:0]   dout_q, din_q;
    logic              wr_cause, unused_wbits;

    assign wr_cause     = wr && (addr == ADDR_W'(OFF_CAUSE));
    assign start        = wr && (addr == ADDR_W'(OFF_DOUT)) && !busy;
    assign unused_wbits = ^wdata;

    // Register updates from the bus and from the shift engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            sel_q   <= '0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            txl_q   <= 1'b0;
            rxl_q   <= 1'b0;
            wide_q  <= 1'b0;
            smp_q   <= SMP_DEFAULT;
            dout_q  <= '0;
            din_q   <= '0;
            cause_q <= 1'b0;
        end else begin
            if (wr) begin
                case (addr)
                    ADDR_W'(OFF_CTRL): begin
                        en_q  <= wdata[CTRL_EN_BIT];
                        sel_q <= wdata[CTRL_SEL_LSB +: SEL_W];
                    end
                    ADDR_W'(OFF_CFG): begin
                        cpol_q <= wdata[CFG_CPOL_BIT];
                        cpha_q <= wdata[CFG_CPHA_BIT];
                        txl_q  <= wdata[CFG_TXLSB_BIT];
                        rxl_q  <= wdata[CFG_RXLSB_BIT];
                        wide_q <= wdata[CFG_WIDE_BIT];
                    end
                    ADDR_W'(OFF_TIMING): smp_q <= wdata[TIM_SMP_LSB +: 2];
                    default: ;
                endcase
            end
            if (start)
                dout_q <= wdata[MAXW-1:0];
            if (done) begin
                din_q   <= rx_word;
                cause_q <= 1'b1;
            end else if (wr_cause) begin
                cause_q <= 1'b0;
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_CTRL): begin
                rdata[CTRL_EN_BIT]             = en_q;
                rdata[CTRL_SEL_LSB +: SEL_W]   = sel_q;
            end
            ADDR_W'(OFF_CFG): begin
                rdata[CFG_CPOL_BIT]  = cpol_q;
                rdata[CFG_CPHA_BIT]  = cpha_q;
                rdata[CFG_TXLSB_BIT] = txl_q;
                rdata[CFG_RXLSB_BIT] = rxl_q;
                rdata[CFG_WIDE_BIT]  = wide_q;
            end
            ADDR_W'(OFF_DOUT):   rdata[MAXW-1:0] = dout_q;
            ADDR_W'(OFF_DIN):    rdata[MAXW-1:0] = din_q;
            ADDR_W'(OFF_CAUSE):  rdata[0] = cause_q;
            ADDR_W'(OFF_TIMING): rdata[TIM_SMP_LSB +: 2] = smp_q;
            default: ;
        endcase
    end

    assign tx_word      = wdata[MAXW-1:0];
    assign shape.cpol   = cpol_q;
    assign shape.cpha   = cpha_q;
    assign shape.tx_lsb = txl_q;
    assign shape.rx_lsb = rxl_q;
    assign shape.wide   = wide_q;
    assign shape.late   = (smp_q == SMP_LATE);
    assign cs_en        = en_q;
    assign cs_sel       = sel_q;

    a_r8_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cause_q);
    a_r10_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(OFF_DOUT) && busy) |=> $stable(dout_q));
endmodule

// File: rtl/spi_host_ctrl.sv
// SPI host controller top: register file, shift engine and chip-select
// decoder. SCLK pacing comes from an external prescaler pulse.
module spi_host_ctrl
    import spim_pkg::*;
#(
    parameter int MAXW     = 16,
    parameter int SHORTW   = 8,
    parameter int CS_COUNT = 8,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                sclk_tick,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [CS_COUNT-1:0] cs_n
);
    localparam int SEL_W = $clog2(CS_COUNT);

    logic             start, busy, done, cs_en;
    logic [MAXW-1:0]  tx_word, rx_word;
    logic [SEL_W-1:0] cs_sel;
    spim_shape_t      shape;

    spim_regs #(
        .MAXW(MAXW), .CS_COUNT(CS_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .done(done),
        .rx_word(rx_word), .start(start), .tx_word(tx_word), .shape(shape),
        .cs_en(cs_en), .cs_sel(cs_sel)
    );

    spim_shift_engine #(.MAXW(MAXW), .SHORTW(SHORTW)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .shape(shape), .tick(sclk_tick), .miso(miso), .sclk(sclk),
        .mosi(mosi), .busy(busy), .done(done), .rx_word(rx_word)
    );

    spim_cs_decode #(.CS_COUNT(CS_COUNT)) u_cs (
        .clk(clk), .rst_n(rst_n), .en(cs_en), .sel(cs_sel), .cs_n(cs_n)
    );
endmodule

// File: tb/spi_host_ctrl_bench.sv
module spi_host_ctrl_bench;
    localparam int DIV = 3;

    logic        clk = 0, rst_n = 0, bus_wr = 0, sclk_tick = 0, miso = 0;
    logic [5:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        sclk, mosi;
    logic [7:0]  cs_n;

    int checks = 0, errors = 0, cyc = 0, tdiv = 0;
    bit finished = 0;

    // Target model state
    int          sl_n = 8, sl_cpha = 0, sl_edges = 0;
    bit          sl_early = 0;
    logic        sl_prev = 0;
    logic [15:0] sl_word = 0, sl_mosi = 0;

    spi_host_ctrl u_spi_host_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_tick(sclk_tick),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Prescaler pulse, one every DIV cycles
    always @(negedge clk) begin
        tdiv = (tdiv == DIV - 1) ? 0 : tdiv + 1;
        sclk_tick = (tdiv == 0);
    end

    // Target: records MOSI on sampling edges, drives MISO on shift edges
    always @(negedge clk) begin
        if (sclk !== sl_prev) begin
            automatic int k = sl_edges;
            sl_edges = sl_edges + 1;
            if ((k % 2) == sl_cpha) begin
                if (k / 2 < 16) sl_mosi[k/2] = mosi;
                if (sl_early) miso = (k / 2 + 1 < sl_n) ? sl_word[k/2+1] : 1'b0;
            end else begin
                automatic int idx = sl_cpha ? k / 2 : (k + 1) / 2;
                miso = (idx < sl_n) ? sl_word[idx] : 1'b0;
            end
        end
        sl_prev = sclk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = 6'(a);
        #1 v = bus_rdata;
    endtask

    task automatic xfer(input int mode, input bit wide, input bit txl, input bit rxl,
                        input bit late, input bit early, input logic [15:0] tx,
                        input logic [15:0] sw, input bit busy_wr);
        automatic int n = wide ? 16 : 8;
        automatic bit cpol = mode[1], cpha = mode[0];
        automatic logic [31:0] v, exp_rx = 0;
        automatic logic [15:0] exp_mo = 0, txm, swm;
        automatic int t0, lat = 0;
        automatic bit seen = 0;
        txm = wide ? tx : {8'h0, tx[7:0]};
        swm = wide ? sw : {8'h0, sw[7:0]};
        wr('h18, late ? 32'h80 : 32'h40);
        wr('h04, (32'(cpol) << 11) | (32'(cpha) << 12) | (32'(txl) << 13) |
                 (32'(rxl) << 14) | (32'(wide) << 5));
        repeat (3) @(negedge clk);
        chk("R3 idle sclk", 32'(sclk), 32'(cpol));
        sl_n = n; sl_cpha = cpha; sl_word = swm; sl_early = early;
        sl_edges = 0; sl_mosi = 0; miso = swm[0];
        wr('h08, 32'hFFFF_0000 | 32'(txm));
        t0 = cyc;
        if (busy_wr) begin
            repeat (4) @(negedge clk);
            wr('h08, 32'(~txm));
        end
        for (int i = 0; i < 2 * n * DIV + 40 && !seen; i++) begin
            rd('h10, v);
            if (v != 0) begin seen = 1; lat = cyc - t0; end
        end
        chk("R8 completion seen", 32'(seen), 1);
        chk("R4 latency in window", 32'(lat >= 2*n*DIV - DIV && lat <= 2*n*DIV + DIV + 6), 1);
        chk("R4 edge count", 32'(sl_edges), 32'(2 * n));
        chk("R3 sclk home", 32'(sclk), 32'(cpol));
        for (int j = 0; j < n; j++)
            exp_mo[j] = txl ? txm[j] : txm[n-1-j];
        chk("R5 R6 mosi bits", 32'(sl_mosi), 32'(exp_mo));
        for (int j = 0; j < n; j++) begin
            automatic logic b = (early && late) ? ((j + 1 < n) ? swm[j+1] : 1'b0) : swm[j];
            exp_rx[rxl ? j : n - 1 - j] = b;
        end
        rd('h0C, v);
        chk("R7 R5 R11 R9 data in", v, exp_rx);
        rd('h08, v);
        chk("R10 data out readback", v, 32'(txm));
        wr('h10, 0);
        rd('h10, v);
        chk("R8 cleared", v, 0);
        if (busy_wr) begin
            repeat (4 * n * DIV) @(negedge clk);
            rd('h10, v);
            chk("R10 no second completion", v, 0);
            chk("R10 no extra edges", 32'(sl_edges), 32'(2 * n));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, d0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk("R1 cs_n", 32'(cs_n), 32'hFF);
        chk("R1 sclk", 32'(sclk), 0);
        chk("R1 mosi", 32'(mosi), 0);
        rd('h00, v); chk("R1 control", v, 0);
        rd('h04, v); chk("R1 config", v, 0);
        rd('h08, v); chk("R1 data out", v, 0);
        rd('h0C, v); chk("R1 data in", v, 0);
        rd('h10, v); chk("R1 cause", v, 0);
        rd('h18, v); chk("R1 timing", v, 32'h40);
        // R2 chip-select sweep
        for (int s = 0; s < 8; s++) begin
            wr('h00, 32'((s << 2) | 1));
            @(negedge clk);
            chk("R2 asserted", 32'(cs_n), 32'(8'(~(8'd1 << s))));
            rd('h00, v); chk("R2 readback", v, 32'((s << 2) | 1));
            wr('h00, 32'(s << 2));
            @(negedge clk);
            chk("R2 released", 32'(cs_n), 32'hFF);
        end
        wr('h00, 32'((5 << 2) | 1));
        // R4 R5 R6 R7: all modes, sizes and orders
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++)
                for (int t = 0; t < 4; t++) begin
                    automatic int i = m * 8 + w * 4 + t;
                    xfer(m, w[0], t[0], t[1], 0, 0,
                         16'hA5C3 ^ 16'(i * 16'h1357), 16'h3C96 + 16'(i * 7919), 0);
                end
        // R11 sample point, normal and early-changing target
        for (int m = 0; m < 4; m++)
            for (int e = 0; e < 2; e++)
                for (int l = 0; l < 2; l++)
                    xfer(m, 1, 0, 1, l[0], e[0], 16'h6E2B + 16'(m * 33),
                         16'hB4D1 ^ 16'(m * 16'h0F0F + e * 3 + l), 0);
        // R9 upper bits zero after an 8-bit exchange following a 16-bit one
        xfer(0, 1, 0, 0, 0, 0, 16'hFFFF, 16'hFFFF, 0);
        xfer(3, 0, 1, 0, 0, 0, 16'h1234, 16'hFF81, 0);
        // R9 data in held across configuration change and idle time
        rd('h0C, d0);
        wr('h04, 32'h0000_7820);
        repeat (30) @(negedge clk);
        rd('h0C, v);
        chk("R9 data in held", v, d0);
        // R10 write during an exchange
        xfer(1, 1, 0, 0, 0, 0, 16'hC0DE, 16'h5A5A, 1);
        xfer(2, 0, 1, 1, 1, 0, 16'h00A7, 16'h0039, 1);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule